// File: doc/BRIEF.md
# Saturating Receive CRC Error Counter

This block keeps an 8-bit statistics tally of received frames that end with a bad frame check sequence. The receive path presents one single-cycle end-of-frame strobe per frame. The strobe carries ready-made flags: CRC bad, address matched and runt. A runt-acceptance enable from the receive configuration comes with them. The block decides whether the frame qualifies and, if it does, adds one to the count.

The host reads the count through a read strobe. While the strobe is high, the current count is visible on the read data output. The counter clears at the end of that access. When a read and a qualifying frame land in the same cycle, the read returns the old count and the counter restarts at one, so no event is lost. The count sticks at its maximum instead of wrapping.

Top module: `rx_crc_err_counter`

## Requirements
- R1: After the active-low asynchronous reset the count is 0, and rd_data_o shows 0.
- R2: A strobed frame with CRC bad, address matched and runt low raises the count by exactly one in the cycle after the strobe.
- R3: A strobed frame with CRC bad and address matched low leaves the count unchanged.
- R4: A strobed frame with CRC bad low leaves the count unchanged, whatever its other flags are.
- R5: A strobed frame with CRC bad, address matched and runt high is counted when runt_accept_i is 1 and ignored when it is 0.
- R6: Frame flags presented while frm_stb_i is low have no effect on the count.
- R7: At 255 the count stays at 255 when further qualifying frames arrive.
- R8: rd_data_o always shows the current count. In a cycle with rd_stb_i high and no qualifying frame, that value is the read result, and the count is 0 in the next cycle.
- R9: In a cycle with rd_stb_i high and a qualifying frame, rd_data_o returns the count from before that frame, and the count is 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frm_stb_i | input | 1 | End-of-frame strobe, one cycle per frame |
| frm_crc_bad_i | input | 1 | Frame ended with a CRC error |
| frm_addr_hit_i | input | 1 | Destination address accepted by the filter |
| frm_runt_i | input | 1 | Frame shorter than the minimum length |
| runt_accept_i | input | 1 | Configuration: count runts with CRC errors |
| rd_stb_i | input | 1 | Host read of the counter; clears it |
| rd_data_o | output | 8 | Current count, the read result while rd_stb_i is high |

## Verification
The qualification logic is driven with every flag combination that matters. Good-CRC frames, bad-CRC frames without an address match, and runts under both enable settings separate each gating term from the others. Flags presented without the strobe check that only the strobe samples them. A long run of qualifying frames tells a counter that sticks at 255 from one that wraps: one read comes just before the limit and one well past it. Reads placed alone, and reads placed on the same cycle as a qualifying frame, separate a plain clear from a clear that keeps the coinciding event.

// File: rtl/rxerr_pkg.sv
package rxerr_pkg;
  localparam int unsigned CNT_W = 8;

  typedef struct packed {
    logic crc_bad;
    logic addr_hit;
    logic runt;
  } frm_flags_t;
endpackage

// File: rtl/rxerr_qualify.sv
module rxerr_qualify
  import rxerr_pkg::*;
(
  input  logic       stb_i,
  input  frm_flags_t flags_i,
  input  logic       runt_accept_i,
  output logic       inc_o
);
  logic len_ok;

  assign len_ok = !flags_i.runt || runt_accept_i;
  assign inc_o  = stb_i && flags_i.crc_bad && flags_i.addr_hit && len_ok;
endmodule

// File: rtl/rxerr_sat_cnt.sv
module rxerr_sat_cnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)                         cnt_d = inc_i ? CNT_ONE : '0; // keep colliding event
    else if (inc_i && cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && inc_i && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + CNT_ONE);
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !inc_i) |=> $stable(cnt_q));
  a_r7_stick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);
  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !inc_i) |=> cnt_q == '0);
  a_r9_collide: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && inc_i) |=> cnt_q == CNT_ONE);
endmodule

// File: rtl/rx_crc_err_counter.sv
module rx_crc_err_counter
  import rxerr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frm_stb_i,
  input  logic             frm_crc_bad_i,
  input  logic             frm_addr_hit_i,
  input  logic             frm_runt_i,
  input  logic             runt_accept_i,
  input  logic             rd_stb_i,
  output logic [CNT_W-1:0] rd_data_o
);
  frm_flags_t flags;
  logic       inc;

  assign flags = '{crc_bad: frm_crc_bad_i, addr_hit: frm_addr_hit_i, runt: frm_runt_i};

  rxerr_qualify u_qual (
    .stb_i        (frm_stb_i),
    .flags_i      (flags),
    .runt_accept_i(runt_accept_i),
    .inc_o        (inc)
  );

  rxerr_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (inc),
    .clr_i (rd_stb_i),
    .cnt_o (rd_data_o)
  );

  a_r3_no_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_stb_i && !frm_addr_hit_i) |=> $stable(rd_data_o));
  a_r4_crc_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_stb_i && !frm_crc_bad_i) |=> $stable(rd_data_o));
  a_r5_runt_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_stb_i && frm_runt_i && !runt_accept_i) |=> $stable(rd_data_o));
endmodule

// File: tb/tb_rx_crc_err_counter.sv
module tb_rx_crc_err_counter;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic stb = 0, crc = 0, hit = 0, runt = 0, acc = 0, rd = 0;
  logic [7:0] rdata;

  int n_cmp = 0, n_bad = 0;
  int model = 0;
  bit done = 0;

  typedef struct {int val; string tag;} exp_t;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_crc_err_counter dut (
    .clk_i(clk), .rst_ni(rst_ni), .frm_stb_i(stb), .frm_crc_bad_i(crc),
    .frm_addr_hit_i(hit), .frm_runt_i(runt), .runt_accept_i(acc),
    .rd_stb_i(rd), .rd_data_o(rdata)
  );

  // driver: one cycle of stimulus; reads push the model's value
  task automatic cyc(input bit s, c, h, r, a, input bit rdx, input string tag);
    bit q;
    @(negedge clk);
    stb = s; crc = c; hit = h; runt = r; acc = a; rd = rdx;
    q = s && c && h && (!r || a);
    if (rdx) begin
      sb_q.push_back('{model, tag});
      model = q ? 1 : 0;
    end else if (q && model != 255) model++;
  endtask

  task automatic rd_chk(input string tag);
    cyc(0, 0, 0, 0, 0, 1, tag);
  endtask

  task automatic good(input int n);
    for (int i = 0; i < n; i++) cyc(1, 1, 1, 0, 0, 0, "");
  endtask

  // monitor: compares read results a little after the drive edge
  always @(negedge clk) begin
    #1;
    if (rd && rst_ni) begin
      exp_t e;
      e = sb_q.pop_front();
      n_cmp++;
      if (rdata !== 8'(e.val)) begin
        n_bad++;
        $display("FAIL %s: rd_data_o=%0d expected=%0d", e.tag, rdata, e.val);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: timeout, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 3);
    n_cmp++;
    if (rdata !== 8'd0) begin
      n_bad++;
      $display("FAIL R1: rd_data_o=%0d in reset expected=0", rdata);
    end
    @(negedge clk); rst_ni = 1'b1;
    rd_chk("R1");
    good(3);           rd_chk("R2");   // 3
    for (int i = 0; i < 4; i++) cyc(1, 1, 0, 0, 1, 0, "");
    rd_chk("R3");                      // 0
    for (int i = 0; i < 4; i++) cyc(1, 0, 1, i[0], 1, 0, "");
    rd_chk("R4");                      // 0
    for (int i = 0; i < 3; i++) cyc(1, 1, 1, 1, 0, 0, "");
    rd_chk("R5 runt off");             // 0
    for (int i = 0; i < 3; i++) cyc(1, 1, 1, 1, 1, 0, "");
    rd_chk("R5 runt on");              // 3
    for (int i = 0; i < 5; i++) cyc(0, 1, 1, 0, 1, 0, "");
    rd_chk("R6");                      // 0
    good(254);         rd_chk("R7 below limit"); // 254
    good(258);         rd_chk("R7 saturated");   // 255
    rd_chk("R8");                      // 0
    good(5);
    cyc(1, 1, 1, 0, 0, 1, "R9 old value");       // 5
    rd_chk("R9 restart at one");       // 1
    rd_chk("R8 empty");                // 0
    @(negedge clk); rd = 0; stb = 0;
    @(negedge clk); #2;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule